// File: doc/BRIEF.md
# Line Sensor Scan Timing Generator

This block produces, from one fast system clock, the drive pattern for a self-scanning photodiode-array line sensor. It generates two non-overlapping scan clocks (`ck_a` first, then `ck_b`), a frame start pulse, and a video-line reset pulse. On every pixel period of an active scan it also issues a sample strobe with a pixel index, so that a downstream converter knows when to capture each video value. The pixel rate follows from two configuration inputs: the high time of each scan clock and the dead time between phases. Both are given in system clock cycles and both have hard lower limits. A third input sets the integration period, which is the spacing between start pulses.

A scan begins in the pixel period that carries the start pulse. Each later period produces one strobe. The scan ends when the sensor's active-low end-of-scan line falls. That line is synchronized and edge-detected inside the block. If the integration period expires before the scan has ended, the next start pulse waits until the end of scan, and a sticky overrun flag is raised. After a synchronous reset all outputs stay low until the enable input is seen.

Top module: `lsg_line_timing`

## Requirements
- R1: `ck_a` and `ck_b` are never high in the same cycle. Each low gap between one phase falling and the other rising lasts max(`gap_cfg`, MIN_GAP) cycles, and MIN_GAP is 1 by default.
- R2: Each scan clock stays high for max(`half_cfg`, MIN_HIGH) cycles, and MIN_HIGH is 2 by default. The phases run in the order `ck_a`, gap, `ck_b`, gap, so the pixel period is 2·high + 2·gap cycles.
- R3: `frame_start` rises in the same cycle as a `ck_b` rising edge. It falls in the cycle in which `ck_a` next rises, so it stays high for high + gap cycles, overlaps the whole of that `ck_b` high time, and contains exactly one `ck_b` falling edge.
- R4: A new start pulse fires at the first `ck_b` rise at which both conditions hold: at least `int_cfg` cycles have passed since the previous start rose, and the current scan has ended. When `int_cfg` is a multiple of the pixel period and the scan ends in time, consecutive starts are exactly `int_cfg` cycles apart.
- R5: `vline_rst` rises one cycle after `ck_b` rises, while `ck_b` is still high. It falls in the cycle in which `ck_a` rises, while `ck_b` is low. It is therefore high for high + gap − 1 cycles in every pixel period.
- R6: `pix_strobe` is high for one cycle, coinciding with the first high cycle of `ck_b`, in each pixel period of an active scan. No strobe is issued in the start period itself. During the k-th strobe of a frame, `pix_idx` equals k−1.
- R7: A falling edge on `scan_done_n` ends the scan. The line passes through two synchronizer flops. After that, no strobe is issued and `pix_idx` holds (at the number of pixels strobed) until the next start pulse, which returns it to 0.
- R8: If the integration period has elapsed at a start opportunity while the scan is still running, `overrun` is set and stays set until reset, and the start is held off as R4 states.
- R9: During and after reset, with `en` low, every output is 0. Once `en` is sampled high, `ck_a` is high in the next cycle, and the first start pulse rises with the first `ck_b` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Starts the scan clocks after reset |
| half_cfg | input | HALF_W | Scan clock high time in cycles (floored at MIN_HIGH) |
| gap_cfg | input | GAP_W | Dead time between phases in cycles (floored at MIN_GAP) |
| int_cfg | input | INT_W | Minimum spacing of start pulses in cycles |
| scan_done_n | input | 1 | Asynchronous end-of-scan from the sensor, active low |
| ck_a | output | 1 | First scan clock phase |
| ck_b | output | 1 | Second scan clock phase |
| frame_start | output | 1 | Start pulse for the sensor shift register |
| vline_rst | output | 1 | Video line reset pulse |
| pix_strobe | output | 1 | One-cycle capture strobe per pixel |
| pix_idx | output | PIX_W | Index of the pixel being strobed |
| overrun | output | 1 | Sticky: integration period shorter than a scan |

## Verification
The bench builds the block with its default parameters: 8-bit phase and gap fields, a 20-bit integration count, a 12-bit pixel index, and floors of 2 high cycles and 1 gap cycle. With these values, zero configuration drives both floors into use, so the minimum 6-cycle pixel period and its dead time are checked directly. A five-pixel sensor model is enough to exercise both an integration period longer than a scan and one shorter than a scan, and with it overrun and start hold-off. The integration counter sits saturated after reset, which lets the first start be checked against the cycle in which `en` was seen.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  // One-hot phase positions; the rotation order is the scan order.
  localparam int PH_A  = 0;
  localparam int PH_GA = 1;
  localparam int PH_B  = 2;
  localparam int PH_GB = 3;
  localparam int PH_N  = 4;

  // Apply a lower bound to a configured length.
  function automatic int unsigned floor_len(int unsigned cfg, int unsigned lo);
    return (cfg < lo) ? lo : cfg;
  endfunction

endpackage

// File: rtl/lsg_eos_sync.sv
module lsg_eos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic fall_evt
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_evt = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/lsg_phase_seq.sv
module lsg_phase_seq #(
  parameter int          HALF_W   = 8,
  parameter int          GAP_W    = 8,
  parameter int unsigned MIN_HIGH = 2,
  parameter int unsigned MIN_GAP  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] half_cfg,
  input  logic [GAP_W-1:0]  gap_cfg,
  output logic              ck_a,
  output logic              ck_b,
  output logic              vline_rst,
  output logic              ev_enter_a,
  output logic              ev_enter_b
);
  import lsg_pkg::*;

  localparam int CNT_W = (HALF_W > GAP_W) ? HALF_W + 1 : GAP_W + 1;

  logic [PH_N-1:0]  ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] hi_m1, gap_m1;
  logic             rst_pulse_q;

  always_comb begin
    hi_m1  = CNT_W'(floor_len(32'(half_cfg), MIN_HIGH) - 1);
    gap_m1 = CNT_W'(floor_len(32'(gap_cfg), MIN_GAP) - 1);
  end

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (ph_q == '0) begin
      if (en) begin
        ph_n  = PH_N'(1) << PH_A;
        cnt_n = hi_m1;
      end
    end else if (cnt_q == '0) begin
      ph_n  = {ph_q[PH_N-2:0], ph_q[PH_N-1]};
      cnt_n = (ph_q[PH_GA] | ph_q[PH_GB]) ? hi_m1 : gap_m1;
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= '0;
      cnt_q       <= '0;
      rst_pulse_q <= 1'b0;
    end else begin
      ph_q        <= ph_n;
      cnt_q       <= cnt_n;
      rst_pulse_q <= (ph_n[PH_B] & ph_q[PH_B]) | ph_n[PH_GB];
    end
  end

  assign ck_a       = ph_q[PH_A];
  assign ck_b       = ph_q[PH_B];
  assign vline_rst  = rst_pulse_q;
  assign ev_enter_b = (cnt_q == '0) & ph_q[PH_GA];
  assign ev_enter_a = (cnt_q == '0) & ph_q[PH_GB];
endmodule

// File: rtl/lsg_frame_ctl.sv
module lsg_frame_ctl #(
  parameter int INT_W = 20,
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_enter_a,
  input  logic             ev_enter_b,
  input  logic             eos_evt,
  input  logic [INT_W-1:0] int_cfg,
  output logic             frame_start,
  output logic             pix_strobe,
  output logic [PIX_W-1:0] pix_idx,
  output logic             overrun,
  output logic             scanning
);
  logic [INT_W-1:0] elapsed_q;
  logic             st_q, strobe_q, ovr_q, scan_q;
  logic [PIX_W-1:0] idx_q;
  logic             due, fire;

  // Cycles elapsed in the coming cycle reach the configured period.
  function automatic logic period_due(logic [INT_W-1:0] cnt, logic [INT_W-1:0] cfg);
    return ({1'b0, cnt} + (INT_W+1)'(1)) >= {1'b0, cfg};
  endfunction

  assign due  = period_due(elapsed_q, int_cfg);
  assign fire = ev_enter_b & ~scan_q & due;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '1;
      st_q      <= 1'b0;
      strobe_q  <= 1'b0;
      ovr_q     <= 1'b0;
      scan_q    <= 1'b0;
      idx_q     <= '0;
    end else begin
      if (fire)                 elapsed_q <= '0;
      else if (elapsed_q != '1) elapsed_q <= elapsed_q + INT_W'(1);

      strobe_q <= ev_enter_b & scan_q & ~eos_evt;

      if (fire)            st_q <= 1'b1;
      else if (ev_enter_a) st_q <= 1'b0;

      if (ev_enter_b & scan_q & due) ovr_q <= 1'b1;

      if (eos_evt)                 scan_q <= 1'b0;
      else if (ev_enter_a & st_q)  scan_q <= 1'b1;

      if (fire)          idx_q <= '0;
      else if (strobe_q) idx_q <= idx_q + PIX_W'(1);
    end
  end

  assign frame_start = st_q;
  assign pix_strobe  = strobe_q;
  assign pix_idx     = idx_q;
  assign overrun     = ovr_q;
  assign scanning    = scan_q;
endmodule

// File: rtl/lsg_line_timing.sv
module lsg_line_timing #(
  parameter int          HALF_W   = 8,
  parameter int          GAP_W    = 8,
  parameter int          INT_W    = 20,
  parameter int          PIX_W    = 12,
  parameter int unsigned MIN_HIGH = 2,
  parameter int unsigned MIN_GAP  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] half_cfg,
  input  logic [GAP_W-1:0]  gap_cfg,
  input  logic [INT_W-1:0]  int_cfg,
  input  logic              scan_done_n,
  output logic              ck_a,
  output logic              ck_b,
  output logic              frame_start,
  output logic              vline_rst,
  output logic              pix_strobe,
  output logic [PIX_W-1:0]  pix_idx,
  output logic              overrun
);
  logic ev_enter_a, ev_enter_b, eos_evt, scanning;

  lsg_eos_sync #(.STAGES(2)) eos_i (
    .clk(clk), .rst(rst), .din_n(scan_done_n), .fall_evt(eos_evt)
  );

  lsg_phase_seq #(
    .HALF_W(HALF_W), .GAP_W(GAP_W), .MIN_HIGH(MIN_HIGH), .MIN_GAP(MIN_GAP)
  ) seq_i (
    .clk(clk), .rst(rst), .en(en), .half_cfg(half_cfg), .gap_cfg(gap_cfg),
    .ck_a(ck_a), .ck_b(ck_b), .vline_rst(vline_rst),
    .ev_enter_a(ev_enter_a), .ev_enter_b(ev_enter_b)
  );

  lsg_frame_ctl #(.INT_W(INT_W), .PIX_W(PIX_W)) frm_i (
    .clk(clk), .rst(rst), .ev_enter_a(ev_enter_a), .ev_enter_b(ev_enter_b),
    .eos_evt(eos_evt), .int_cfg(int_cfg), .frame_start(frame_start),
    .pix_strobe(pix_strobe), .pix_idx(pix_idx), .overrun(overrun),
    .scanning(scanning)
  );
endmodule

// File: rtl/lsg_line_timing_chk.sv
module lsg_line_timing_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ck_a,
  input logic             ck_b,
  input logic             frame_start,
  input logic             vline_rst,
  input logic             pix_strobe,
  input logic [PIX_W-1:0] pix_idx,
  input logic             overrun
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst) !(ck_a && ck_b));
  a_r1_dead_after_a: assert property (@(posedge clk) disable iff (rst) $fell(ck_a) |-> !ck_b);
  a_r1_dead_after_b: assert property (@(posedge clk) disable iff (rst) $fell(ck_b) |-> !ck_a);
  a_r2_min_high_a: assert property (@(posedge clk) disable iff (rst) $fell(ck_a) |-> $past(ck_a, 2));
  a_r2_min_high_b: assert property (@(posedge clk) disable iff (rst) $fell(ck_b) |-> $past(ck_b, 2));
  a_r3_start_rise: assert property (@(posedge clk) disable iff (rst) $rose(frame_start) |-> $rose(ck_b));
  a_r3_start_fall: assert property (@(posedge clk) disable iff (rst) $fell(frame_start) |-> $rose(ck_a));
  a_r5_reset_rise: assert property (@(posedge clk) disable iff (rst) $rose(vline_rst) |-> (ck_b && $past(ck_b)));
  a_r5_reset_fall: assert property (@(posedge clk) disable iff (rst) $fell(vline_rst) |-> !ck_b);
  a_r6_strobe_edge: assert property (@(posedge clk) disable iff (rst) pix_strobe |-> $rose(ck_b));
  a_r7_index_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(pix_idx) |-> ($past(pix_strobe) || frame_start));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst) $past(overrun) |-> overrun);
endmodule

bind lsg_line_timing lsg_line_timing_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst(rst), .ck_a(ck_a), .ck_b(ck_b), .frame_start(frame_start),
  .vline_rst(vline_rst), .pix_strobe(pix_strobe), .pix_idx(pix_idx),
  .overrun(overrun)
);

// File: tb/lsg_line_timing_tb_top.sv
module lsg_line_timing_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, en, scan_done_n;
  logic [7:0]  half_cfg, gap_cfg;
  logic [19:0] int_cfg;
  logic        ck_a, ck_b, frame_start, vline_rst, pix_strobe, overrun;
  logic [11:0] pix_idx;

  lsg_line_timing dut_i (
    .clk(clk), .rst(rst), .en(en), .half_cfg(half_cfg), .gap_cfg(gap_cfg),
    .int_cfg(int_cfg), .scan_done_n(scan_done_n), .ck_a(ck_a), .ck_b(ck_b),
    .frame_start(frame_start), .vline_rst(vline_rst), .pix_strobe(pix_strobe),
    .pix_idx(pix_idx), .overrun(overrun)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit done = 0;

  int t_a_rise, t_a_fall, t_b_rise, t_b_fall, t_st_rise, t_rp_rise, t_first_st;
  int len_a, len_b, gap_ab, gap_ba, st_len, st_int, rp_len, rp_lag;
  int v_overlap, v_st, v_rp, v_samp, v_pix;
  int frames, samp_in_frame, last_frame_samples, pix_before_st, pix_at_st;
  int npix, eos_hold;
  logic p_a, p_b, p_st, p_rp;
  logic [11:0] p_pix;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_track();
    t_a_rise = 0; t_a_fall = 0; t_b_rise = 0; t_b_fall = 0; t_st_rise = 0;
    t_rp_rise = 0; t_first_st = 0;
    len_a = 0; len_b = 0; gap_ab = 0; gap_ba = 0; st_len = 0; st_int = 0;
    rp_len = 0; rp_lag = 0;
    v_overlap = 0; v_st = 0; v_rp = 0; v_samp = 0; v_pix = 0;
    frames = 0; samp_in_frame = 0; last_frame_samples = 0;
    pix_before_st = 0; pix_at_st = 0; eos_hold = 0;
    p_a = 0; p_b = 0; p_st = 0; p_rp = 0; p_pix = '0;
  endtask

  // One cycle: sample at the falling edge, track events, model the sensor.
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (ck_a && ck_b) v_overlap++;
    if (ck_a && !p_a) begin
      if (t_b_fall > 0) gap_ba = cyc - t_b_fall;
      t_a_rise = cyc;
    end
    if (!ck_a && p_a) begin t_a_fall = cyc; len_a = cyc - t_a_rise; end
    if (ck_b && !p_b) begin
      if (t_a_fall > 0) gap_ab = cyc - t_a_fall;
      t_b_rise = cyc;
    end
    if (!ck_b && p_b) begin t_b_fall = cyc; len_b = cyc - t_b_rise; end
    if (frame_start && !p_st) begin
      if (!(ck_b && !p_b)) v_st++;
      if (t_st_rise > 0) st_int = cyc - t_st_rise;
      t_st_rise = cyc;
      frames++;
      if (frames == 1) t_first_st = cyc;
      last_frame_samples = samp_in_frame;
      samp_in_frame = 0;
      pix_before_st = int'(p_pix);
      pix_at_st = int'(pix_idx);
    end
    if (!frame_start && p_st) begin
      if (!(ck_a && !p_a)) v_st++;
      st_len = cyc - t_st_rise;
    end
    if (vline_rst && !p_rp) begin
      if (!(ck_b && p_b)) v_rp++;
      rp_lag = cyc - t_b_rise;
      t_rp_rise = cyc;
    end
    if (!vline_rst && p_rp) begin
      if (ck_b) v_rp++;
      rp_len = cyc - t_rp_rise;
    end
    if (eos_hold > 0) begin
      eos_hold--;
      if (eos_hold == 0) scan_done_n = 1'b1;
    end
    if (pix_strobe) begin
      if (!(ck_b && !p_b)) v_samp++;
      if (int'(pix_idx) != samp_in_frame) v_pix++;
      samp_in_frame++;
      if (samp_in_frame == npix) begin scan_done_n = 1'b0; eos_hold = 2; end
    end
    p_a = ck_a; p_b = ck_b; p_st = frame_start; p_rp = vline_rst; p_pix = pix_idx;
  endtask

  task automatic start_dut(int h, int g, int ic, int np);
    rst = 1'b1; en = 1'b0; scan_done_n = 1'b1;
    half_cfg = 8'(h); gap_cfg = 8'(g); int_cfg = 20'(ic); npix = np;
    repeat (3) tick();
    rst = 1'b0;
    clear_track();
  endtask

  // R9: quiet until enable, then first phase and first start at fixed cycles.
  task automatic t_reset();
    int act = 0;
    int e_cyc;
    start_dut(3, 2, 60, 5);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (ck_a || ck_b || frame_start || vline_rst || pix_strobe || overrun || pix_idx != 0)
        act++;
    end
    chk_eq("R9", "active outputs while en low", act, 0);
    en = 1'b1;
    e_cyc = cyc;
    tick();
    chk_eq("R9", "ck_a one cycle after en", int'(ck_a), 1);
    repeat (30) tick();
    chk_eq("R9", "first start cycle after en", t_first_st - e_cyc, 1 + 3 + 2);
    chk_eq("R3", "start aligned to ck_b rise (violations)", v_st, 0);
  endtask

  // R1 R2 R3 R5: waveform shape for one configuration.
  task automatic t_shape(int h, int g);
    int he = (h < 2) ? 2 : h;
    int ge = (g < 1) ? 1 : g;
    start_dut(h, g, 0, 1000);
    en = 1'b1;
    repeat (200) tick();
    chk_eq("R1", "overlap cycles", v_overlap, 0);
    chk_eq("R1", "gap a->b", gap_ab, ge);
    chk_eq("R1", "gap b->a", gap_ba, ge);
    chk_eq("R2", "ck_a high", len_a, he);
    chk_eq("R2", "ck_b high", len_b, he);
    chk_eq("R3", "start length", st_len, he + ge);
    chk_eq("R3", "start edge violations", v_st, 0);
    chk_eq("R5", "reset lag after ck_b rise", rp_lag, 1);
    chk_eq("R5", "reset length", rp_len, he + ge - 1);
    chk_eq("R5", "reset edge violations", v_rp, 0);
  endtask

  // R4 R6 R7 R8: full scans with a five-pixel sensor model.
  task automatic t_scan(int ic, int exp_int, int exp_ovr);
    start_dut(2, 1, ic, 5);
    en = 1'b1;
    for (int i = 0; i < 3000 && frames < 4; i++) tick();
    chk_eq("R4", "start interval", st_int, exp_int);
    chk_eq("R6", "strobes per frame", last_frame_samples, 5);
    chk_eq("R6", "strobe alignment violations", v_samp, 0);
    chk_eq("R6", "pixel index violations", v_pix, 0);
    chk_eq("R7", "index held before start", pix_before_st, 5);
    chk_eq("R7", "index cleared at start", pix_at_st, 0);
    chk_eq("R8", "overrun flag", int'(overrun), exp_ovr);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; scan_done_n = 1'b1;
    half_cfg = '0; gap_cfg = '0; int_cfg = '0; npix = 0;
    clear_track();
    t_reset();
    t_shape(3, 2);
    t_shape(0, 0);
    t_shape(5, 1);
    t_scan(60, 60, 0);
    t_scan(12, 36, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule